// File: doc/BRIEF.md
# Repeat-Mode DMA Channel with Half-Way Interrupt

This block is one DMA channel. It copies 32-bit words from a peripheral data register, whose address stays fixed, into a memory buffer. The buffer address grows by one word after each transfer. Each transfer is started by a request from the peripheral. The channel reads the word through a single-beat memory master port and then writes it to the buffer. When the write has completed, the channel returns a one-cycle acknowledge.

In repeat mode the channel restarts by itself at the end of each round. It reloads the destination address and the transfer count from backup registers, so software never has to reprogram it. A half-way flag is raised when the remaining count drops to half of the backup count, and an end flag is raised when the count reaches zero. With these two flags software can treat one buffer as two halves. It works on the half that has just been filled while the channel fills the other half.

Top module: `dma_rpt_chan`

## Requirements
- R1: For every transfer the channel reads from the source address, which never changes. It writes the word it read to the current destination address, and the destination then increases by 4.
- R2: Each request that the channel accepts produces exactly one read and one write. The acknowledge is a single-cycle pulse that follows the cycle in which the memory accepted the write.
- R3: When the remaining count after a transfer equals the backup count divided by two (rounded down, so 5 gives 2), the half flag (control bit 4) is set.
- R4: When the remaining count after a transfer is zero, the end flag (control bit 5) is set.
- R5: If repeat mode is on (control bit 1), reaching zero reloads the count from the backup count (register 4) and the destination from the backup destination (register 3).
- R6: If repeat mode is off, the count stays at zero and no further requests are accepted.
- R7: Transfers start only while both the channel enable (control bit 0) and the master enable (register 6, bit 0) are 1.
- R8: Writing 0 to a flag bit of the control register (register 5) clears that flag. Writing 1 to a flag bit leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R9: The irq output is high when (half flag AND half-interrupt enable, bit 3) is true, or when (end flag AND end-interrupt enable, bit 2) is true.
- R10: While the channel is disabled, a write to the destination (register 1) or the count (register 2) also loads the matching backup register. While the channel is enabled, writes to registers 1 and 2 are ignored.
- R11: After reset all registers read as 0, and irq, acknowledge and memory request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 backup destination, 4 backup count, 5 control, 6 master |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Peripheral acknowledge pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ready_i | input | 1 | Memory access completes this cycle |
| irq_o | output | 1 | Interrupt output |

## Verification
The case that is hardest to reach from the ports is the wrap at the end of a round. There, one completing transfer has to set the end flag, reload both the count and the destination, and possibly set the half flag as well, while software may be clearing a flag in the same cycle. The stimulus runs full rounds of requests with memory latencies that vary from transfer to transfer. It then starts a second round and checks that the addresses restart at the backup destination. It also runs an odd count, so that the truncated half point is reached. A behavioural model follows the count and the flags and compares irq and every memory beat on each clock.

// File: rtl/dma_rpt_pkg.sv
package dma_rpt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_ACK} xfer_st_e;

  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_CNT    = 3'd2;
  localparam logic [2:0] REG_DST_BK = 3'd3;
  localparam logic [2:0] REG_CNT_BK = 3'd4;
  localparam logic [2:0] REG_CTRL   = 3'd5;
  localparam logic [2:0] REG_MASTER = 3'd6;

  localparam int CB_EN    = 0;
  localparam int CB_RPT   = 1;
  localparam int CB_IE    = 2;
  localparam int CB_HIE   = 3;
  localparam int CB_HALF  = 4;
  localparam int CB_END   = 5;
endpackage

// File: rtl/dma_rpt_regs.sv
module dma_rpt_regs
  import dma_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              done_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              run_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] src_q, dst_q, dst_bk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_bk_q, cnt_dec, half_pt;
  logic en_q, rpt_q, ie_q, hie_q, half_q, end_q, master_q;
  logic hit_half, hit_end, wr_ctrl;

  assign cnt_dec  = cnt_q - CNT_W'(1);
  assign half_pt  = cnt_bk_q >> 1;
  assign hit_half = done_i && (cnt_dec == half_pt);
  assign hit_end  = done_i && (cnt_dec == '0);
  assign wr_ctrl  = reg_we_i && (reg_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; dst_bk_q <= '0;
      cnt_q <= '0; cnt_bk_q <= '0;
      en_q <= 1'b0; rpt_q <= 1'b0; ie_q <= 1'b0; hie_q <= 1'b0;
      half_q <= 1'b0; end_q <= 1'b0; master_q <= 1'b0;
    end else begin
      if (done_i) begin
        if (hit_end && rpt_q) begin
          cnt_q <= cnt_bk_q;
          dst_q <= dst_bk_q;
        end else begin
          cnt_q <= cnt_dec;
          dst_q <= dst_q + STEP;
        end
      end
      if (reg_we_i) begin
        unique case (reg_addr_i)
          REG_SRC:    src_q <= reg_wdata_i[ADDR_W-1:0];
          REG_DST:    if (!en_q && !done_i) begin
                        dst_q    <= reg_wdata_i[ADDR_W-1:0];
                        dst_bk_q <= reg_wdata_i[ADDR_W-1:0];
                      end
          REG_CNT:    if (!en_q && !done_i) begin
                        cnt_q    <= reg_wdata_i[CNT_W-1:0];
                        cnt_bk_q <= reg_wdata_i[CNT_W-1:0];
                      end
          REG_DST_BK: dst_bk_q <= reg_wdata_i[ADDR_W-1:0];
          REG_CNT_BK: cnt_bk_q <= reg_wdata_i[CNT_W-1:0];
          REG_CTRL: begin
            en_q  <= reg_wdata_i[CB_EN];
            rpt_q <= reg_wdata_i[CB_RPT];
            ie_q  <= reg_wdata_i[CB_IE];
            hie_q <= reg_wdata_i[CB_HIE];
          end
          REG_MASTER: master_q <= reg_wdata_i[0];
          default: ;
        endcase
      end
      // flag set beats a same-cycle clear
      half_q <= (half_q & ~(wr_ctrl & ~reg_wdata_i[CB_HALF])) | hit_half;
      end_q  <= (end_q  & ~(wr_ctrl & ~reg_wdata_i[CB_END]))  | hit_end;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_SRC:    reg_rdata_o = DATA_W'(src_q);
      REG_DST:    reg_rdata_o = DATA_W'(dst_q);
      REG_CNT:    reg_rdata_o = DATA_W'(cnt_q);
      REG_DST_BK: reg_rdata_o = DATA_W'(dst_bk_q);
      REG_CNT_BK: reg_rdata_o = DATA_W'(cnt_bk_q);
      REG_CTRL:   reg_rdata_o = DATA_W'({end_q, half_q, hie_q, ie_q, rpt_q, en_q});
      REG_MASTER: reg_rdata_o = DATA_W'(master_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign run_o = en_q && master_q && (cnt_q != '0);
  assign irq_o = (half_q && hie_q) || (end_q && ie_q);

  AST_DST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !(cnt_q == CNT_W'(1) && rpt_q) |=> dst_q == $past(dst_q) + STEP); // R1
  AST_ROUND_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cnt_q == CNT_W'(1) && rpt_q && !reg_we_i
      |=> cnt_q == $past(cnt_bk_q) && dst_q == $past(dst_bk_q)); // R5
  AST_END_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && cnt_q == CNT_W'(1) |=> end_q); // R4
  AST_CNT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == REG_CNT && en_q && !done_i |=> cnt_q == $past(cnt_q)); // R10
endmodule

// File: rtl/dma_rpt_xfer.sv
module dma_rpt_xfer
  import dma_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              dreq_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              dack_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  xfer_st_e st_q, st_d;
  logic [DATA_W-1:0] buf_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (run_i && dreq_i) st_d = ST_RD;
      ST_RD:   if (mem_ready_i) st_d = ST_WR;
      ST_WR:   if (mem_ready_i) st_d = ST_ACK;
      ST_ACK:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RD && mem_ready_i) buf_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? dst_i : src_i;
  assign mem_wdata_o = buf_q;
  assign dack_o      = (st_q == ST_ACK);
  assign done_o      = dack_o;

  AST_NO_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE && !run_i |=> !mem_req_o); // R7
  AST_ACK_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> $past(mem_req_o && mem_we_o && mem_ready_i)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |=> !dack_o); // R2
endmodule

// File: rtl/dma_rpt_chan.sv
module dma_rpt_chan
  import dma_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dreq_i,
  output logic              dack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              irq_o
);
  logic              done, run;
  logic [ADDR_W-1:0] src, dst;

  dma_rpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .done_i(done), .src_o(src), .dst_o(dst), .run_o(run), .irq_o
  );

  dma_rpt_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni, .run_i(run), .dreq_i, .src_i(src), .dst_i(dst),
    .dack_o, .done_o(done), .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .mem_ready_i
  );
endmodule

// File: tb/dma_rpt_chan_tb_top.sv
module dma_rpt_chan_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dreq = 1'b0, dack_o, mem_req_o, mem_we_o, irq_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  always #5 clk = ~clk;

  dma_rpt_chan dut_i (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
    .dack_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .irq_o
  );

  int checks = 0, errors = 0;
  int lat = 0, lat_cfg = 0, rd_seq = 0, acks = 0;
  bit mon_on = 0, blk_win = 0;
  logic [31:0] dq[$];

  // behavioural model
  logic [31:0] m_src = 0, m_dst = 0, m_dbk = 0;
  int m_cnt = 0, m_cbk = 0;
  bit m_en = 0, m_rpt = 0, m_ie = 0, m_hie = 0, m_hf = 0, m_ef = 0, m_me = 0;

  function automatic bit m_irq();
    return (m_hf && m_hie) || (m_ef && m_ie);
  endfunction
  function automatic logic [31:0] m_ctrl();
    return {26'd0, m_ef, m_hf, m_hie, m_ie, m_rpt, m_en};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      3'd0: m_src = d;
      3'd1: if (!m_en) begin m_dst = d; m_dbk = d; end
      3'd2: if (!m_en) begin m_cnt = int'(d[15:0]); m_cbk = int'(d[15:0]); end
      3'd3: m_dbk = d;
      3'd4: m_cbk = int'(d[15:0]);
      3'd5: begin
        m_en = d[0]; m_rpt = d[1]; m_ie = d[2]; m_hie = d[3];
        m_hf = m_hf & d[4]; m_ef = m_ef & d[5];
      end
      3'd6: m_me = d[0];
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic do_xfer();
    int t;
    @(negedge clk);
    dreq = 1'b1;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!dack_o && t < 100);
    chk(dack_o === 1'b1, "R2 ack", {31'd0, dack_o}, 32'd1);
    dreq = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    logic [31:0] v;
    rd(3'd5, v); chk(v === m_ctrl(), tag, v, m_ctrl());
    rd(3'd2, v); chk(v === 32'(m_cnt), tag, v, 32'(m_cnt));
    rd(3'd1, v); chk(v === m_dst, tag, v, m_dst);
  endtask

  // memory responder
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      lat = lat_cfg;
    end else if (mem_req_o) begin
      if (lat == 0) begin
        mem_ready = 1'b1;
        if (!mem_we_o) begin
          chk(mem_addr_o === m_src, "R1 src addr", mem_addr_o, m_src);
          mem_rdata = 32'hC0DE_0000 + 32'(rd_seq);
          dq.push_back(mem_rdata);
          rd_seq++;
        end else begin
          logic [31:0] e;
          e = (dq.size() > 0) ? dq.pop_front() : 32'hDEAD_BEEF;
          chk(mem_addr_o === m_dst, "R1 dst addr", mem_addr_o, m_dst);
          chk(mem_wdata_o === e, "R1 data", mem_wdata_o, e);
        end
      end else lat--;
    end
  end

  // per-clock comparison with the model
  always begin
    @(posedge clk);
    #2;
    if (rst_ni && mon_on) begin
      chk(irq_o === m_irq(), "R9 irq", {31'd0, irq_o}, {31'd0, m_irq()});
      if (blk_win) chk(mem_req_o === 1'b0, "R6/R7 blocked", {31'd0, mem_req_o}, 32'd0);
      if (dack_o) begin
        acks++;
        m_cnt--;
        m_dst += 4;
        if (m_cnt == m_cbk / 2) m_hf = 1;
        if (m_cnt == 0) begin
          m_ef = 1;
          if (m_rpt) begin m_cnt = m_cbk; m_dst = m_dbk; end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int a0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    mon_on = 1;
    // R11 reset state
    for (int r = 0; r < 7; r++) begin
      rd(3'(r), v); chk(v === 32'd0, "R11 reg reset", v, 0);
    end
    chk({irq_o, dack_o, mem_req_o} === 3'b000, "R11 outputs", {29'd0, irq_o, dack_o, mem_req_o}, 0);
    // R8 writing 1 to flags has no effect
    wr(3'd5, 32'h30);
    rd(3'd5, v); chk(v === 32'd0, "R8 write one", v, 0);

    wr(3'd0, 32'h1000_0040);
    wr(3'd1, 32'h2000_0100);
    wr(3'd2, 32'd8);
    rd(3'd3, v); chk(v === 32'h2000_0100, "R10 dst backup", v, 32'h2000_0100);
    rd(3'd4, v); chk(v === 32'd8, "R10 cnt backup", v, 8);
    wr(3'd5, 32'h0F);
    // R7 master off blocks transfers
    a0 = acks;
    @(negedge clk); dreq = 1'b1; blk_win = 1;
    repeat (20) @(negedge clk);
    blk_win = 0; dreq = 1'b0;
    chk(acks == a0, "R7 no ack", 32'(acks), 32'(a0));
    rd(3'd2, v); chk(v === 32'd8, "R7 count held", v, 8);

    wr(3'd6, 32'd1);
    for (int i = 0; i < 8; i++) begin
      lat_cfg = i % 3;
      do_xfer();
      chk_state("R3,R4,R5 state");
      if (i == 2) chk(v[4] === 1'b0 && m_hf == 0, "R3 not yet", v, 0);
    end
    chk(irq_o === 1'b1, "R9 both flags", {31'd0, irq_o}, 1);
    rd(3'd2, v); chk(v === 32'd8, "R5 cnt reload", v, 8);
    rd(3'd1, v); chk(v === 32'h2000_0100, "R5 dst reload", v, 32'h2000_0100);
    wr(3'd5, 32'h2F);
    rd(3'd5, v); chk(v === 32'h2F, "R8 clear half only", v, 32'h2F);
    wr(3'd5, 32'h0F);
    rd(3'd5, v); chk(v === 32'h0F, "R8 clear end", v, 32'h0F);
    // R10 count write ignored while enabled
    wr(3'd2, 32'd3);
    rd(3'd2, v); chk(v === 32'd8, "R10 locked", v, 8);

    for (int i = 0; i < 8; i++) begin
      lat_cfg = (i + 1) % 4;
      do_xfer();
      chk_state("R5 second round");
    end
    wr(3'd5, 32'h00);

    // odd count: half point 2
    wr(3'd2, 32'd5);
    wr(3'd1, 32'h3000_0000);
    rd(3'd4, v); chk(v === 32'd5, "R10 odd backup", v, 5);
    wr(3'd5, 32'h0B);
    for (int i = 0; i < 5; i++) begin
      lat_cfg = 1;
      do_xfer();
      chk_state("R3 odd");
      if (i == 1) begin rd(3'd5, v); chk(v[4] === 1'b0, "R3 odd early", v, 32'h0B); end
      if (i == 2) begin rd(3'd5, v); chk(v[4] === 1'b1, "R3 odd half", v, 32'h1B); end
    end
    wr(3'd5, 32'h2B);
    chk(irq_o === 1'b0, "R9 end masked", {31'd0, irq_o}, 0);

    // non-repeat stop
    wr(3'd5, 32'h00);
    wr(3'd2, 32'd3);
    wr(3'd1, 32'h4000_0000);
    wr(3'd5, 32'h05);
    for (int i = 0; i < 3; i++) begin
      lat_cfg = 0;
      do_xfer();
      chk_state("R4,R6 single");
    end
    a0 = acks;
    @(negedge clk); dreq = 1'b1; blk_win = 1;
    repeat (20) @(negedge clk);
    blk_win = 0; dreq = 1'b0;
    chk(acks == a0, "R6 stopped", 32'(acks), 32'(a0));
    rd(3'd2, v); chk(v === 32'd0, "R6 count zero", v, 0);
    rd(3'd1, v); chk(v === 32'h4000_000C, "R6 dst end", v, 32'h4000_000C);
    chk(irq_o === 1'b1, "R9 end irq", {31'd0, irq_o}, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule